// File: doc/BRIEF.md
# Triggered Line Pixel Serializer

This block drives a single 1-bit video output pin, one line at a time. Right after reset it waits for a configuration word on its input stream. That word gives the number of pixels in each line. After that it sits idle until a start-of-line strobe arrives. It then serializes exactly that many pixel bits onto the output pin and returns to idle for the next strobe. Each pixel is stretched over a fixed number of clocks (four by default). This lets a pixel clock that is a quarter of the system clock be produced without a second clock domain.

Pixel bits arrive packed in 32-bit words on a valid/ready stream. A word is unpacked starting at its least significant bit. The stream is continuous across lines, so bits left over at the end of one line open the next line. The input holds one word in a buffer. Ready is raised only when that buffer is empty, which is the back-pressure rule. A word that is offered while ready is high is taken on that clock edge. The source must keep valid high and the data stable until the word is accepted. If no bit is available when a pixel slot begins, the pixel is driven low and a sticky underrun flag is raised.

Top module: `line_pixel_serializer`

## Requirements
- R1: The first word accepted after reset sets the pixel count per line, taken from its low 16 bits. Ready stays high until that word is accepted, and start strobes seen before it leave the output low.
- R2: A strobe sampled high while the block is idle starts a line of exactly the configured number of pixels. Pixel j appears on the output during clock cycles 4j+1 through 4j+4 after the edge that sampled the strobe.
- R3: Each pixel value stays on the output for exactly 4 consecutive clock cycles.
- R4: Bits are taken from each word starting with bit 0 and ending with bit 31, and a word is finished after 32 pixels. Bits that are still unread when a line ends are used first on the next line.
- R5: Outside a line the output is low. A strobe sampled on the clock edge that ends the last pixel is ignored. A strobe sampled one edge later starts a new line.
- R6: If no bit is available when a pixel slot begins, that pixel is driven low and the underrun flag goes high. The flag stays high until reset, and the missing pixel consumes no stream bit.
- R7: A strobe that arrives while a line is being shifted has no effect on the line's length, its timing or its bits.
- R8: A configured pixel count of zero makes every strobe produce no pixels.
- R9: After configuration, ready is high only while the block holds no unread word. A word can be accepted on the same edge that its first bit is needed.
- R10: During and right after reset the output and the underrun flag are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 32 | Stream word: configuration first, then packed pixel bits |
| s_valid | input | 1 | Stream word is offered |
| s_ready | output | 1 | Block accepts the offered word on this edge |
| line_start | input | 1 | Start-of-visible-line strobe |
| pix_out | output | 1 | Serialized pixel output |
| underrun | output | 1 | Sticky flag: a pixel slot found no data |

## Verification
The strobe is sampled on an edge, and pixel j becomes visible just after the edge 4j later. It therefore occupies the falling-edge samples 4j through 4j+3 counted from the first falling edge after that strobe edge, and the bench compares every one of those samples against bits it computes from its own word generator. The underrun flag rises together with the first starved pixel, so it is checked low on the sample before that slot and high on the slot's first sample. Ready changes only on clock edges. The stream driver therefore reads it at the falling edge to learn whether the next rising edge will take a word, and it keeps its own count of delivered words. Strobes are raised at a falling edge so that they land on a chosen rising edge, including the edge that ends a line.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    ST_CFG  = 2'd0,
    ST_IDLE = 2'd1,
    ST_LINE = 2'd2
  } lps_state_e;

endpackage

// File: rtl/lps_line_ctrl.sv
module lps_line_ctrl
  import lps_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HOLD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [CNT_W-1:0] cfg_word,
  input  logic             line_start,
  output logic             in_cfg,
  output logic             line_active,
  output logic             pix_start,
  output logic             line_end,
  output logic [CNT_W-1:0] line_len
);

  localparam int PH_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HOLD - 1);

  lps_state_e       state_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] idx_q;
  logic [PH_W-1:0]  phase_q;

  logic begin_line;
  logic last_phase;
  logic last_pix;

  assign in_cfg      = (state_q == ST_CFG);
  assign line_active = (state_q == ST_LINE);
  assign line_len    = len_q;

  // a zero length never leaves idle
  assign begin_line = (state_q == ST_IDLE) && line_start && (len_q != '0);
  assign last_phase = line_active && (phase_q == PH_LAST);
  assign last_pix   = (idx_q == len_q - CNT_W'(1));

  assign pix_start = begin_line || (last_phase && !last_pix);
  assign line_end  = last_phase && last_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CFG;
      len_q   <= '0;
      idx_q   <= '0;
      phase_q <= '0;
    end else begin
      unique case (state_q)
        ST_CFG: begin
          if (s_valid) begin
            len_q   <= cfg_word;
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (begin_line) begin
            state_q <= ST_LINE;
            idx_q   <= '0;
            phase_q <= '0;
          end
        end
        ST_LINE: begin
          if (last_phase) begin
            phase_q <= '0;
            if (last_pix) state_q <= ST_IDLE;
            else          idx_q   <= idx_q + CNT_W'(1);
          end else begin
            phase_q <= phase_q + PH_W'(1);
          end
        end
        default: state_q <= ST_CFG;
      endcase
    end
  end

endmodule

// File: rtl/lps_word_unpacker.sv
module lps_word_unpacker #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              take,
  output logic              bit_ok,
  output logic              bit_val
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] buf_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;
  logic              fire;

  assign s_ready = enable && !full_q;
  assign fire    = s_valid && s_ready;

  // an arriving word can serve the slot that begins on this very edge
  assign bit_ok  = full_q || fire;
  assign bit_val = full_q ? buf_q[idx_q] : s_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (full_q) begin
      if (take) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == IDX_LAST) full_q <= 1'b0;
      end
    end else if (fire) begin
      buf_q <= s_data;
      if (take) begin
        idx_q  <= IDX_W'(1);
        full_q <= (WORD_W > 1);
      end else begin
        idx_q  <= '0;
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lps_out_stage.sv
module lps_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_start,
  input  logic line_end,
  input  logic bit_ok,
  input  logic bit_val,
  output logic pix_out,
  output logic underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out  <= 1'b0;
      underrun <= 1'b0;
    end else if (pix_start) begin
      pix_out <= bit_ok & bit_val;
      if (!bit_ok) underrun <= 1'b1;
    end else if (line_end) begin
      pix_out <= 1'b0;
    end
  end

endmodule

// File: rtl/line_pixel_serializer.sv
module line_pixel_serializer #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int HOLD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              line_start,
  output logic              pix_out,
  output logic              underrun
);

  logic             in_cfg;
  logic             line_active;
  logic             pix_start;
  logic             line_end;
  logic [CNT_W-1:0] line_len;
  logic             unpack_ready;
  logic             bit_ok;
  logic             bit_val;

  lps_line_ctrl #(
    .CNT_W(CNT_W),
    .HOLD (HOLD)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .cfg_word   (s_data[CNT_W-1:0]),
    .line_start (line_start),
    .in_cfg     (in_cfg),
    .line_active(line_active),
    .pix_start  (pix_start),
    .line_end   (line_end),
    .line_len   (line_len)
  );

  lps_word_unpacker #(
    .WORD_W(WORD_W)
  ) i_unpack (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (!in_cfg),
    .s_data (s_data),
    .s_valid(s_valid),
    .s_ready(unpack_ready),
    .take   (pix_start),
    .bit_ok (bit_ok),
    .bit_val(bit_val)
  );

  lps_out_stage i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_start(pix_start),
    .line_end (line_end),
    .bit_ok   (bit_ok),
    .bit_val  (bit_val),
    .pix_out  (pix_out),
    .underrun (underrun)
  );

  assign s_ready = in_cfg | unpack_ready;

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int CNT_W = 16,
  parameter int HOLD  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_cfg,
  input logic             line_active,
  input logic             pix_start,
  input logic             line_end,
  input logic [CNT_W-1:0] line_len,
  input logic             bit_ok,
  input logic             pix_out,
  input logic             underrun
);

  logic [CNT_W-1:0] pix_cnt;
  logic [7:0]       ph_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt <= '0;
      ph_cnt  <= '0;
    end else begin
      if (pix_start) pix_cnt <= line_active ? pix_cnt + CNT_W'(1) : '0;
      if (pix_start)        ph_cnt <= '0;
      else if (line_active) ph_cnt <= ph_cnt + 8'd1;
    end
  end

  AST_CFG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cfg |=> !in_cfg); // R1

  AST_LINE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> (pix_cnt == line_len - CNT_W'(1))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_active && !pix_start && !line_end |=> $stable(pix_out)); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |-> !pix_out); // R5

  AST_UNDERRUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start && !bit_ok |=> (!pix_out && underrun)); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R6

  AST_FULL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_active && (pix_start || line_end) |-> (ph_cnt == 8'(HOLD - 1))); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cfg && (line_len == '0) |-> !line_active); // R8

endmodule

bind line_pixel_serializer lps_checker #(
  .CNT_W(CNT_W),
  .HOLD (HOLD)
) i_lps_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_cfg     (in_cfg),
  .line_active(line_active),
  .pix_start  (pix_start),
  .line_end   (line_end),
  .line_len   (line_len),
  .bit_ok     (bit_ok),
  .pix_out    (pix_out),
  .underrun   (underrun)
);

// File: tb/test_line_pixel_serializer.sv
module test_line_pixel_serializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_data;
  logic        s_valid;
  logic        s_ready;
  logic        line_start = 1'b0;
  logic        pix_out;
  logic        underrun;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  logic [31:0] cfg_word = 32'd0;
  bit          feed_en = 1'b0;
  bit          stall_en = 1'b0;
  int          feed_limit = 1000000;
  int          widx = 0;
  bit          fire_next = 1'b0;
  int          stall_run = 0;
  int          g = 0;

  always #10 clk = ~clk;

  line_pixel_serializer i_line_pixel_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .line_start(line_start),
    .pix_out   (pix_out),
    .underrun  (underrun)
  );

  function automatic logic [31:0] data_word(int k);
    logic [31:0] v;
    v = 32'(k) * 32'h9E3779B9 + 32'h01234567;
    return v ^ (32'(k) << 7);
  endfunction

  function automatic logic exp_bit(int idx);
    logic [31:0] w;
    w = data_word(idx / 32);
    return w[idx % 32];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stream source: word 0 is the configuration, then data words
  initial begin
    bit keep;
    s_valid = 1'b0;
    s_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        widx = 0; fire_next = 1'b0; s_valid = 1'b0; stall_run = 0;
      end else begin
        keep = s_valid && !fire_next;
        if (fire_next) widx++;
        if (keep) begin
          s_valid = 1'b1;
        end else if (feed_en && widx < feed_limit) begin
          if (stall_en && stall_run < 2 && ($urandom % 3) == 0) begin
            s_valid = 1'b0; stall_run++;
          end else begin
            s_valid = 1'b1; stall_run = 0;
            s_data = (widx == 0) ? cfg_word : data_word(widx - 1);
          end
        end else begin
          s_valid = 1'b0;
        end
        fire_next = s_valid && s_ready;
      end
    end
  end

  task automatic do_reset(logic [31:0] cfg);
    feed_en = 1'b0; stall_en = 1'b0; feed_limit = 1000000;
    line_start = 1'b0; cfg_word = cfg; g = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle_low(int n, string req);
    for (int i = 0; i < n; i++) begin
      check(pix_out === 1'b0, req, pix_out, 0);
      @(negedge clk);
    end
  endtask

  task automatic wait_words(int n);
    while (widx < n) @(negedge clk);
  endtask

  // strobe at this falling edge; avail = pixels that have data
  task automatic run_line(int n, int mid, int avail, bit chk_under);
    logic e;
    e = 1'b0;
    line_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < 4 * n; k++) begin
      if (k % 4 == 0) begin
        if (k / 4 < avail) begin e = exp_bit(g); g++; end
        else e = 1'b0;
        check(pix_out === e, (k / 4 < avail) ? "R4" : "R6", pix_out, e);
      end else begin
        check(pix_out === e, "R3", pix_out, e);
      end
      if (chk_under && k == 4 * avail - 1) check(underrun === 1'b0, "R6", underrun, 0);
      if (chk_under && k == 4 * avail)     check(underrun === 1'b1, "R6", underrun, 1);
      if (k == mid) line_start = 1'b1;
      if (k == mid + 1) line_start = 1'b0;
      @(negedge clk);
    end
    line_start = 1'b0;
    check(pix_out === 1'b0, "R5", pix_out, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    @(negedge clk);

    // R10 reset state
    do_reset(32'd640);
    check(pix_out === 1'b0, "R10", pix_out, 0);
    check(underrun === 1'b0, "R10", underrun, 0);
    check(s_ready === 1'b1, "R10", s_ready, 1);

    // R1 strobe before configuration is ignored
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    idle_low(8, "R1");
    check(s_ready === 1'b1, "R1", s_ready, 1);

    // R1 / R2 configure 640 pixels, two full lines
    feed_en = 1'b1;
    wait_words(1);
    idle_low(6, "R1");
    check(s_ready === 1'b0, "R9", s_ready, 0);
    run_line(640, -1, 1 << 30, 1'b0);
    idle_low(3, "R5");
    run_line(640, 20, 1 << 30, 1'b0);
    check(underrun === 1'b0, "R6", underrun, 0);

    // R4 / R7 odd length with stalls, random gaps and stray strobes
    do_reset(32'd37);
    stall_en = 1'b1; feed_en = 1'b1;
    wait_words(1);
    idle_low(6, "R1");
    for (int l = 0; l < 12; l++) begin
      int mid;
      mid = (($urandom % 3) == 0) ? int'($urandom % 148) : -1;
      run_line(37, mid, 1 << 30, 1'b0);
      idle_low(int'($urandom % 4), "R5");
    end
    // R5 strobe on the edge that ends the last pixel is ignored
    run_line(37, 4 * 37 - 1, 1 << 30, 1'b0);
    idle_low(6, "R7");
    // back to back: strobe on the very next edge
    run_line(37, -1, 1 << 30, 1'b0);
    run_line(37, -1, 1 << 30, 1'b0);
    check(underrun === 1'b0, "R9", underrun, 0);

    // single pixel lines
    do_reset(32'd1);
    feed_en = 1'b1;
    wait_words(1);
    idle_low(4, "R1");
    for (int l = 0; l < 40; l++) begin
      run_line(1, -1, 1 << 30, 1'b0);
      idle_low(1, "R5");
    end

    // R8 zero length
    do_reset(32'd0);
    feed_en = 1'b1;
    wait_words(1);
    idle_low(3, "R8");
    run_line(0, -1, 1 << 30, 1'b0);
    idle_low(10, "R8");

    // R6 underrun with one data word available
    do_reset(32'd40);
    feed_limit = 2; feed_en = 1'b1;
    wait_words(2);
    idle_low(4, "R1");
    run_line(40, -1, 32, 1'b1);
    check(underrun === 1'b1, "R6", underrun, 1);
    check(s_ready === 1'b1, "R9", s_ready, 1);
    feed_limit = 1000000;
    idle_low(4, "R5");
    run_line(40, -1, 1 << 30, 1'b0);
    check(underrun === 1'b1, "R6", underrun, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule